// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM Core

This block is a clocked true dual-port memory with two fully independent ports, called left and right. Either port can read or write any word in any cycle, with no regard to what the other port is doing. Each word is 16 bits and is split into an upper byte lane (bits 15..8) and a lower byte lane (bits 7..0). Each lane has its own active-low select, so software can read or write a single byte without a read-modify-write cycle. The address width is a parameter. The full chip builds the block with a 14-bit address, which gives 16K words. The default is a 10-bit address so that the default elaboration stays small.

Each port has an active-low write-hold input, which is driven by a collision arbiter outside the block. While the hold is low, the port's writes are dropped and its reads carry on as normal. Read data is registered, so it appears one clock after the request. A two-bit valid flag comes with it, one bit per lane. A lane that is not read shows a cleared valid bit and zero data. This stands in for an output bus that is not driven.

Each port classifies its controls in every cycle into one of four access kinds:
- `ACC_IDLE`: the chip enable is high, or a read is requested with the output enable high.
- `ACC_READ`: the enable is low, the direction input is high and the output enable is low.
- `ACC_WRITE`: the enable is low, the direction input is low and the hold is high.
- `ACC_HELD`: a write is requested while the hold is low.

The kind is decoded again in every cycle from that cycle's inputs. There is no stored state, so a port can move from any kind to any other between two cycles. The kind then steers the per-lane write and read strobes.

Top module: `dpram_bytelane`

## Requirements
- R1: A port writes the memory only in a cycle where its chip enable is low and its direction input is low. A write request with the chip enable high changes nothing.
- R2: The upper-byte select (active low) gates data bits 15..8 and the lower-byte select gates bits 7..0, for both writes and reads. With both selects high, no byte is touched.
- R3: A read is requested when chip enable is low, direction is high and output enable is low. The read returns the stored lane data on the read bus one cycle later. The valid flag bit 1 belongs to the upper lane and bit 0 to the lower lane. A lane whose valid bit is 0 reads as zero.
- R4: With output enable high, both valid bits are 0 and the read bus is zero in the next cycle, whatever the other controls are.
- R5: With the hold input low, the port's writes leave the memory unchanged, and its reads still return data as in R3.
- R6: The two ports work independently in the same cycle, at any pair of addresses.
- R7: When both ports write the same address and the same lane in one cycle and neither port is held, the left port's data is stored.
- R8: A read of an address that the other port writes in the same cycle returns the contents from before that write.
- R9: While reset is low, and in the first cycle after it, both valid flags are 0 and both read buses are zero. Memory contents are not initialised by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of read flags and read data |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rnw | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper-byte select, active low |
| l_lb_n | input | 1 | Left lower-byte select, active low |
| l_hold_n | input | 1 | Left write hold from the arbiter, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, zero in lanes not valid |
| l_rvalid | output | 2 | Left per-lane read valid (1 upper, 0 lower) |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rnw | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper-byte select, active low |
| r_lb_n | input | 1 | Right lower-byte select, active low |
| r_hold_n | input | 1 | Right write hold from the arbiter, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, zero in lanes not valid |
| r_rvalid | output | 2 | Right per-lane read valid (1 upper, 0 lower) |

## Verification
Two functions can fall in one cycle: a write from one port, and either a write or a read of the same word and lane from the other port. The first case resolves by left priority. The second case must return the old contents. The bench provokes both cases by confining most random addresses to eight words, so that many cycles have both ports on one address with random lanes, holds and directions. It also drives both cases directly. Every outcome is judged against a bench reference model. In each cycle the model computes the read results before it applies the writes, and it applies the right port's write before the left port's.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_HELD  = 2'd3
    } acc_e;
endpackage

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl #(
    parameter int LANES = 2
) (
    input  logic               ce_n,
    input  logic               rnw,
    input  logic               oe_n,
    input  logic               hold_n,
    input  logic [LANES-1:0]   sel_n,
    output dpr_pkg::acc_e      acc,
    output logic [LANES-1:0]   lane_wr,
    output logic [LANES-1:0]   lane_rd
);
    import dpr_pkg::*;

    // access classification
    always_comb begin
        if (ce_n) begin
            acc = ACC_IDLE;
        end else if (rnw) begin
            acc = oe_n ? ACC_IDLE : ACC_READ;
        end else begin
            acc = hold_n ? ACC_WRITE : ACC_HELD;
        end
    end

    // strobe outputs per access kind
    always_comb begin
        lane_wr = '0;
        lane_rd = '0;
        unique case (acc)
            ACC_IDLE:  ;
            ACC_READ:  lane_rd = ~sel_n;
            ACC_WRITE: lane_wr = ~sel_n;
            ACC_HELD:  ;
        endcase
    end
endmodule

// File: rtl/dpr_lane_bank.sv
module dpr_lane_bank #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [LANE_W-1:0] a_wd,
    output logic [LANE_W-1:0] a_q,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [LANE_W-1:0] b_wd,
    output logic [LANE_W-1:0] b_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    // port a (left) is written last so it wins a same-word collision
    always_ff @(posedge clk) begin
        if (b_wr) mem[b_addr] <= b_wd;
        if (a_wr) mem[a_addr] <= a_wd;
        if (a_rd) a_q <= mem[a_addr];
        if (b_rd) b_q <= mem[b_addr];
    end

    // R7: left data survives a same-word same-lane double write
    a_r7_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && b_wr && a_addr == b_addr) |=> mem[$past(a_addr)] == $past(a_wd));

    // R8: a read colliding with the other port's write sees old contents
    a_r8_a_reads_old: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd && b_wr && a_addr == b_addr && !a_wr) |=> a_q == $past(mem[a_addr]));

    a_r8_b_reads_old: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rd && a_wr && a_addr == b_addr && !b_wr) |=> b_q == $past(mem[b_addr]));

    // R1: with no strobe the addressed word is left as it was
    a_r1_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_wr && !b_wr) |=> mem[$past(a_addr)] == $past(mem[a_addr]));
endmodule

// File: rtl/dpr_read_out.sv
module dpr_read_out #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_rd,
    input  logic [LANES*LANE_W-1:0] q,
    output logic [LANES-1:0]        rvalid,
    output logic [LANES*LANE_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rvalid <= '0;
        else        rvalid <= lane_rd;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_gate
        assign rdata[i*LANE_W +: LANE_W] = rvalid[i] ? q[i*LANE_W +: LANE_W] : '0;

        // R3: a lane not flagged valid presents zero
        a_r3_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
            !rvalid[i] |-> rdata[i*LANE_W +: LANE_W] == '0);
    end
endmodule

// File: rtl/dpram_bytelane.sv
module dpram_bytelane #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_rnw,
    input  logic              l_oe_n,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic              l_hold_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic [1:0]        l_rvalid,
    input  logic              r_ce_n,
    input  logic              r_rnw,
    input  logic              r_oe_n,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic              r_hold_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic [1:0]        r_rvalid
);
    import dpr_pkg::*;

    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    acc_e             l_acc, r_acc;
    logic [LANES-1:0] l_wr, l_rd, r_wr, r_rd;
    logic [DATA_W-1:0] l_q, r_q;

    dpr_port_ctl #(.LANES(LANES)) u_lctl (
        .ce_n(l_ce_n), .rnw(l_rnw), .oe_n(l_oe_n), .hold_n(l_hold_n),
        .sel_n({l_ub_n, l_lb_n}), .acc(l_acc), .lane_wr(l_wr), .lane_rd(l_rd)
    );

    dpr_port_ctl #(.LANES(LANES)) u_rctl (
        .ce_n(r_ce_n), .rnw(r_rnw), .oe_n(r_oe_n), .hold_n(r_hold_n),
        .sel_n({r_ub_n, r_lb_n}), .acc(r_acc), .lane_wr(r_wr), .lane_rd(r_rd)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        dpr_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .a_addr(l_addr),
            .a_wr  (l_wr[i]),
            .a_rd  (l_rd[i]),
            .a_wd  (l_wdata[i*LANE_W +: LANE_W]),
            .a_q   (l_q[i*LANE_W +: LANE_W]),
            .b_addr(r_addr),
            .b_wr  (r_wr[i]),
            .b_rd  (r_rd[i]),
            .b_wd  (r_wdata[i*LANE_W +: LANE_W]),
            .b_q   (r_q[i*LANE_W +: LANE_W])
        );
    end

    dpr_read_out #(.LANES(LANES), .LANE_W(LANE_W)) u_lout (
        .clk(clk), .rst_n(rst_n), .lane_rd(l_rd), .q(l_q),
        .rvalid(l_rvalid), .rdata(l_rdata)
    );

    dpr_read_out #(.LANES(LANES), .LANE_W(LANE_W)) u_rout (
        .clk(clk), .rst_n(rst_n), .lane_rd(r_rd), .q(r_q),
        .rvalid(r_rvalid), .rdata(r_rdata)
    );

    // R1: a decoded write needs enable low and direction low
    a_r1_write_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (l_acc == ACC_WRITE) |-> (!l_ce_n && !l_rnw && l_hold_n));

    // R4: output enable high blanks the next read result
    a_r4_left_oe_blank: assert property (@(posedge clk) disable iff (!rst_n)
        l_oe_n |=> (l_rvalid == 2'b00 && l_rdata == '0));

    a_r4_right_oe_blank: assert property (@(posedge clk) disable iff (!rst_n)
        r_oe_n |=> (r_rvalid == 2'b00 && r_rdata == '0));

    // R5: a held port still reads
    a_r5_held_read_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_hold_n && !r_ce_n && r_rnw && !r_oe_n && !r_lb_n) |=> r_rvalid[0]);

    // R3: an upper-lane valid flag comes only from a requested upper read
    a_r3_upper_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_rvalid[1]) |-> $past(!l_ce_n && l_rnw && !l_oe_n && !l_ub_n));
endmodule

// File: tb/tb_dpram_bytelane.sv
module tb_dpram_bytelane;
    localparam int AW    = 10;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          ce_n [2];
    logic          rnw  [2];
    logic          oe_n [2];
    logic          ub_n [2];
    logic          lb_n [2];
    logic          hold_n [2];
    logic [AW-1:0] addr [2];
    logic [DW-1:0] wd   [2];
    logic [DW-1:0] rdata [2];
    logic [1:0]    rvalid [2];

    logic [DW-1:0] ref_mem [DEPTH];
    int vectors = 0;
    int errors  = 0;

    dpram_bytelane #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(ce_n[0]), .l_rnw(rnw[0]), .l_oe_n(oe_n[0]), .l_ub_n(ub_n[0]),
        .l_lb_n(lb_n[0]), .l_hold_n(hold_n[0]), .l_addr(addr[0]), .l_wdata(wd[0]),
        .l_rdata(rdata[0]), .l_rvalid(rvalid[0]),
        .r_ce_n(ce_n[1]), .r_rnw(rnw[1]), .r_oe_n(oe_n[1]), .r_ub_n(ub_n[1]),
        .r_lb_n(lb_n[1]), .r_hold_n(hold_n[1]), .r_addr(addr[1]), .r_wdata(wd[1]),
        .r_rdata(rdata[1]), .r_rvalid(rvalid[1])
    );

    task automatic idle(input int p);
        ce_n[p] = 1'b1; rnw[p] = 1'b1; oe_n[p] = 1'b1; ub_n[p] = 1'b0;
        lb_n[p] = 1'b0; hold_n[p] = 1'b1; addr[p] = '0; wd[p] = '0;
    endtask

    task automatic setp(input int p, input logic c, input logic r, input logic o,
                        input logic u, input logic l, input logic h,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        ce_n[p] = c; rnw[p] = r; oe_n[p] = o; ub_n[p] = u; lb_n[p] = l;
        hold_n[p] = h; addr[p] = a; wd[p] = d;
    endtask

    function automatic logic [1:0] exp_valid(input int p);
        if (!ce_n[p] && rnw[p] && !oe_n[p]) return {~ub_n[p], ~lb_n[p]};
        return 2'b00;
    endfunction

    function automatic logic [DW-1:0] exp_data(input int p, input logic [1:0] v);
        logic [DW-1:0] w;
        w = ref_mem[addr[p]];
        return {v[1] ? w[15:8] : 8'h00, v[0] ? w[7:0] : 8'h00};
    endfunction

    // one clock: expected reads from the old model, then writes right then left
    task automatic run(input string tag);
        logic [1:0]    ev [2];
        logic [DW-1:0] ed [2];
        for (int p = 0; p < 2; p++) begin
            ev[p] = exp_valid(p);
            ed[p] = exp_data(p, ev[p]);
        end
        for (int p = 1; p >= 0; p--) begin
            if (!ce_n[p] && !rnw[p] && hold_n[p]) begin
                if (!ub_n[p]) ref_mem[addr[p]][15:8] = wd[p][15:8];
                if (!lb_n[p]) ref_mem[addr[p]][7:0]  = wd[p][7:0];
            end
        end
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            vectors++;
            if (rvalid[p] !== ev[p] || rdata[p] !== ed[p]) begin
                errors++;
                $display("FAIL %s port %0d: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                         tag, p, rvalid[p], rdata[p], ev[p], ed[p]);
            end
        end
    endtask

    task automatic check_idle_out(input string tag);
        for (int p = 0; p < 2; p++) begin
            vectors++;
            if (rvalid[p] !== 2'b00 || rdata[p] !== '0) begin
                errors++;
                $display("FAIL %s port %0d: rvalid=%b rdata=%h expected rvalid=00 rdata=0000",
                         tag, p, rvalid[p], rdata[p]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog: cycles=200000 expected end before 200000");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D2C_3B4A));
        idle(0); idle(1);
        repeat (3) @(negedge clk);
        check_idle_out("R9");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_out("R9");

        // fill every word from the left port
        for (int a = 0; a < DEPTH; a++) begin
            setp(0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, AW'(a), DW'(a * 16'h9E37) ^ 16'h5A5A);
            run("R1");
        end
        idle(0);

        // R1: chip enable high blocks a write
        setp(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd3, 16'hFFFF); run("R1");
        setp(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd3, 16'h0000); run("R1");

        // R2: upper-only write, then full and lower-only reads
        setp(0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'd4, 16'h1234); run("R2");
        setp(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd4, 16'h0000); run("R2");
        setp(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd4, 16'hFFFF); run("R2");
        setp(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd4, 16'h0000); run("R2");

        // R3: lower lane only read
        setp(0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 10'd4, 16'h0000); run("R3");

        // R4: output enable high
        setp(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 10'd4, 16'h0000); run("R4");
        idle(0);

        // R5: held write dropped, held read still works
        setp(1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd6, 16'hBEEF); run("R5");
        setp(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd6, 16'h0000); run("R5");

        // R7: both ports write one word
        setp(0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd7, 16'hAAAA);
        setp(1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd7, 16'h5555); run("R7");
        idle(1);
        setp(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd7, 16'h0000); run("R7");

        // R8: right reads the word the left writes
        setp(0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd8, 16'h0F0F);
        setp(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd8, 16'h0000); run("R8");
        idle(0);
        run("R8");

        // R6: random traffic on both ports, mostly colliding addresses
        for (int n = 0; n < 3000; n++) begin
            for (int p = 0; p < 2; p++) begin
                ce_n[p]   = ($urandom % 5) == 0;
                rnw[p]    = $urandom % 2;
                oe_n[p]   = ($urandom % 6) == 0;
                ub_n[p]   = ($urandom % 4) == 0;
                lb_n[p]   = ($urandom % 4) == 0;
                hold_n[p] = ($urandom % 5) != 0;
                addr[p]   = (($urandom % 4) == 0) ? AW'($urandom) : AW'($urandom % 8);
                wd[p]     = DW'($urandom);
            end
            run("R6");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule